// File: doc/BRIEF.md
# TCP Receive Notification Consumer

This block is the user-side driver for the receive half of a streaming TCP offload engine. After reset it asks the engine to open a configured local port for listening. It then waits for the engine's answer. If the port opened, the block starts taking event notifications from the engine. If it did not, the block stops and issues nothing more.

Each notification names a session. It reports either that bytes are waiting in the engine's receive buffer or that the far end has closed the connection. For a data event the block sends an explicit read request carrying the session and the byte count. It then takes the payload the engine streams back on a 512-bit (64 bytes per beat) data channel and counts the valid bytes from each beat's keep mask. A close event retires the session through a one-cycle pulse.

Read requests may run ahead of the payload. A short queue of requested lengths lets each returned stream be checked against its own request. A mismatch between the last flag and the requested length raises a sticky error.

Top module: `tcp_rx_consumer`

## Requirements
- R1: From reset the block offers a listen request carrying `cfgPort` and holds it, port unchanged, until the engine accepts it; `notifReady` stays low until a successful listen result.
- R2: `status` encodes 0 = listen pending, 1 = running, 2 = listen refused. A response with `listenRspOk` high moves to running. A response with it low moves to refused, and the block then keeps `notifReady`, `rdReqValid` and `listenValid` low until reset.
- R3: An accepted notification with `notifClosed` low and a non-zero `notifLength` produces, from the next cycle, one read request with the same session and length, held stable until `rdReqReady`.
- R4: An accepted notification with `notifClosed` high raises `retireValid` for one cycle in the next cycle, with `retireSession` equal to its session, and issues no read request even if the length is non-zero.
- R5: An accepted notification with `notifClosed` low and a length of zero is dropped: no read request and no retire pulse follow.
- R6: `payReady` is high only while at least one read request has completed its handshake and its payload has not yet ended with `payLast`; payload is never taken before its request.
- R7: `byteCount` grows by the number of set bits of `payKeep` (bit i marks byte i valid) for every accepted payload beat, and is otherwise unchanged.
- R8: `lenError` is set when an accepted beat's `payLast` disagrees with whether that beat's valid bytes reach the bytes still owed for its request; once set it stays set until reset.
- R9: Up to `LEN_DEPTH` completed read requests may await payload. `notifReady` is low while that queue is full or a read request is still waiting for `rdReqReady`, and payload streams are matched to requests in issue order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgPort | input | PORT_W | Local TCP port to open for listening |
| listenValid | output | 1 | Listen request valid |
| listenPort | output | PORT_W | Port carried by the listen request |
| listenReady | input | 1 | Engine accepts the listen request |
| listenRspValid | input | 1 | Listen result valid |
| listenRspOk | input | 1 | Listen result: 1 port open, 0 refused |
| listenRspReady | output | 1 | Block accepts the listen result |
| notifValid | input | 1 | Notification valid |
| notifSession | input | SESS_W | Session named by the notification |
| notifLength | input | LEN_W | Bytes waiting in the receive buffer |
| notifClosed | input | 1 | Far end closed the session |
| notifReady | output | 1 | Block accepts the notification |
| rdReqValid | output | 1 | Read request valid |
| rdReqSession | output | SESS_W | Session to read from |
| rdReqLength | output | LEN_W | Bytes to read |
| rdReqReady | input | 1 | Engine accepts the read request |
| payValid | input | 1 | Payload beat valid |
| payKeep | input | DATA_W/8 | Byte-valid mask of the beat |
| payLast | input | 1 | Final beat of one read |
| payReady | output | 1 | Block accepts the payload beat |
| retireValid | output | 1 | One-cycle pulse: session retired |
| retireSession | output | SESS_W | Session being retired |
| byteCount | output | CNT_W | Running count of received bytes |
| lenError | output | 1 | Sticky payload length mismatch |
| status | output | 2 | 0 listen pending, 1 running, 2 refused |

## Verification
Suppose the length queue lost or duplicated an entry. Within one payload beat of the affected read, `payReady` would then differ from its expected value, or `lenError` would rise on a correct stream. A control state stuck in the wrong phase shows up on the first cycle as a wrong `notifReady`, `listenValid` or `status`. A wrongly captured request shows up on the first cycle `rdReqValid` is high, as a wrong session or length. The bench runs a behavioural model with queues and compares every output on every clock, so any such fault is reported in the cycle it first reaches a port.

// File: rtl/tcp_rx_pkg.sv
package tcp_rx_pkg;

  // Externally visible link phase
  typedef enum logic [1:0] {
    ST_OPEN = 2'd0,
    ST_RUN  = 2'd1,
    ST_FAIL = 2'd2
  } linkStatus_e;

  // Control sequencer phases
  typedef enum logic [1:0] {
    C_LISTEN_REQ  = 2'd0,
    C_LISTEN_WAIT = 2'd1,
    C_RUN         = 2'd2,
    C_FAIL        = 2'd3
  } ctrlState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic pushLen;    // a read request completed its handshake this cycle
    logic payEnable;  // payload may be taken (link running)
  } ctrlStrobe_t;

endpackage

// File: rtl/tcp_rx_len_fifo.sv
module tcp_rx_len_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wrPtr;
  logic [AW-1:0] rdPtr;
  logic [CW-1:0] fill;

  logic doPush;
  logic doPop;

  assign empty  = (fill == '0);
  assign full   = (fill == CW'(DEPTH));
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign dout   = mem[rdPtr];

  // one storage cell per entry
  for (genvar g = 0; g < DEPTH; g++) begin : gCell
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        mem[g] <= '0;
      end else if (doPush && (wrPtr == AW'(g))) begin
        mem[g] <= din;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      fill  <= '0;
    end else begin
      if (doPush) begin
        wrPtr <= (wrPtr == AW'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      end
      if (doPop) begin
        rdPtr <= (rdPtr == AW'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      end
      case ({doPush, doPop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end
endmodule

// File: rtl/tcp_rx_ctrl.sv
module tcp_rx_ctrl
  import tcp_rx_pkg::*;
#(
  parameter int SESS_W = 16,
  parameter int LEN_W  = 16,
  parameter int PORT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PORT_W-1:0] cfgPort,
  output logic              listenValid,
  output logic [PORT_W-1:0] listenPort,
  input  logic              listenReady,
  input  logic              listenRspValid,
  input  logic              listenRspOk,
  output logic              listenRspReady,
  input  logic              notifValid,
  input  logic [SESS_W-1:0] notifSession,
  input  logic [LEN_W-1:0]  notifLength,
  input  logic              notifClosed,
  output logic              notifReady,
  output logic              rdReqValid,
  output logic [SESS_W-1:0] rdReqSession,
  output logic [LEN_W-1:0]  rdReqLength,
  input  logic              rdReqReady,
  output logic              retireValid,
  output logic [SESS_W-1:0] retireSession,
  input  logic              lenFifoFull,
  output ctrlStrobe_t       strobe,
  output linkStatus_e       status
);
  ctrlState_e state;

  logic notifTake;
  logic wantRead;
  logic reqDone;

  assign listenValid    = (state == C_LISTEN_REQ);
  assign listenPort     = cfgPort;
  assign listenRspReady = (state == C_LISTEN_WAIT);
  assign notifReady     = (state == C_RUN) && !rdReqValid && !lenFifoFull;

  assign notifTake = notifValid && notifReady;
  assign wantRead  = notifTake && !notifClosed && (notifLength != '0);
  assign reqDone   = rdReqValid && rdReqReady;

  assign strobe.pushLen   = reqDone;
  assign strobe.payEnable = (state == C_RUN);

  always_comb begin
    case (state)
      C_RUN:   status = ST_RUN;
      C_FAIL:  status = ST_FAIL;
      default: status = ST_OPEN;
    endcase
  end

  // phase sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= C_LISTEN_REQ;
    end else begin
      case (state)
        C_LISTEN_REQ:  if (listenReady) state <= C_LISTEN_WAIT;
        C_LISTEN_WAIT: if (listenRspValid) state <= listenRspOk ? C_RUN : C_FAIL;
        default:       state <= state;
      endcase
    end
  end

  // read request holding register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdReqValid   <= 1'b0;
      rdReqSession <= '0;
      rdReqLength  <= '0;
    end else begin
      if (reqDone) begin
        rdReqValid <= 1'b0;
      end
      if (wantRead) begin
        rdReqValid   <= 1'b1;
        rdReqSession <= notifSession;
        rdReqLength  <= notifLength;
      end
    end
  end

  // session retire pulse
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      retireValid   <= 1'b0;
      retireSession <= '0;
    end else begin
      retireValid <= notifTake && notifClosed;
      if (notifTake && notifClosed) begin
        retireSession <= notifSession;
      end
    end
  end
endmodule

// File: rtl/tcp_rx_datapath.sv
module tcp_rx_datapath
  import tcp_rx_pkg::*;
#(
  parameter int LEN_W  = 16,
  parameter int KEEP_W = 64,
  parameter int DEPTH  = 4,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [LEN_W-1:0]  pushLenValue,
  input  logic              payValid,
  input  logic [KEEP_W-1:0] payKeep,
  input  logic              payLast,
  output logic              payReady,
  output logic              lenFifoFull,
  output logic [CNT_W-1:0]  byteCount,
  output logic              lenError
);
  localparam int BB_W = $clog2(KEEP_W + 1);

  logic [LEN_W-1:0] headLen;
  logic             lenEmpty;
  logic             beatTake;
  logic [BB_W-1:0]  beatBytes;
  logic [LEN_W-1:0] beatExt;
  logic [LEN_W-1:0] remBytes;
  logic             inRead;
  logic [LEN_W-1:0] curRem;
  logic             expectEnd;

  function automatic logic [BB_W-1:0] countKeep(input logic [KEEP_W-1:0] k);
    logic [BB_W-1:0] n;
    n = '0;
    for (int i = 0; i < KEEP_W; i++) begin
      n = n + BB_W'(k[i]);
    end
    return n;
  endfunction

  tcp_rx_len_fifo #(
    .W     (LEN_W),
    .DEPTH (DEPTH)
  ) u_lenFifo (
    .clk   (clk),
    .rstN  (rstN),
    .push  (strobe.pushLen),
    .din   (pushLenValue),
    .pop   (beatTake && payLast),
    .dout  (headLen),
    .empty (lenEmpty),
    .full  (lenFifoFull)
  );

  assign payReady  = !lenEmpty && strobe.payEnable;
  assign beatTake  = payValid && payReady;
  assign beatBytes = countKeep(payKeep);
  assign beatExt   = LEN_W'(beatBytes);
  assign curRem    = inRead ? remBytes : headLen;
  assign expectEnd = (beatExt >= curRem);

  // bytes still owed for the read at the head of the queue
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remBytes <= '0;
      inRead   <= 1'b0;
    end else if (beatTake) begin
      if (payLast) begin
        inRead   <= 1'b0;
        remBytes <= '0;
      end else begin
        inRead   <= 1'b1;
        remBytes <= expectEnd ? '0 : (curRem - beatExt);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteCount <= '0;
      lenError  <= 1'b0;
    end else if (beatTake) begin
      byteCount <= byteCount + CNT_W'(beatBytes);
      if (payLast != expectEnd) begin
        lenError <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tcp_rx_consumer.sv
module tcp_rx_consumer
  import tcp_rx_pkg::*;
#(
  parameter int SESS_W    = 16,
  parameter int LEN_W     = 16,
  parameter int PORT_W    = 16,
  parameter int DATA_W    = 512,
  parameter int LEN_DEPTH = 4,
  parameter int CNT_W     = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [PORT_W-1:0]   cfgPort,
  output logic                listenValid,
  output logic [PORT_W-1:0]   listenPort,
  input  logic                listenReady,
  input  logic                listenRspValid,
  input  logic                listenRspOk,
  output logic                listenRspReady,
  input  logic                notifValid,
  input  logic [SESS_W-1:0]   notifSession,
  input  logic [LEN_W-1:0]    notifLength,
  input  logic                notifClosed,
  output logic                notifReady,
  output logic                rdReqValid,
  output logic [SESS_W-1:0]   rdReqSession,
  output logic [LEN_W-1:0]    rdReqLength,
  input  logic                rdReqReady,
  input  logic                payValid,
  input  logic [DATA_W/8-1:0] payKeep,
  input  logic                payLast,
  output logic                payReady,
  output logic                retireValid,
  output logic [SESS_W-1:0]   retireSession,
  output logic [CNT_W-1:0]    byteCount,
  output logic                lenError,
  output logic [1:0]          status
);
  localparam int KEEP_W = DATA_W / 8;

  ctrlStrobe_t strobe;
  linkStatus_e linkStatus;
  logic        lenFifoFull;

  assign status = linkStatus;

  tcp_rx_ctrl #(
    .SESS_W (SESS_W),
    .LEN_W  (LEN_W),
    .PORT_W (PORT_W)
  ) u_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .cfgPort        (cfgPort),
    .listenValid    (listenValid),
    .listenPort     (listenPort),
    .listenReady    (listenReady),
    .listenRspValid (listenRspValid),
    .listenRspOk    (listenRspOk),
    .listenRspReady (listenRspReady),
    .notifValid     (notifValid),
    .notifSession   (notifSession),
    .notifLength    (notifLength),
    .notifClosed    (notifClosed),
    .notifReady     (notifReady),
    .rdReqValid     (rdReqValid),
    .rdReqSession   (rdReqSession),
    .rdReqLength    (rdReqLength),
    .rdReqReady     (rdReqReady),
    .retireValid    (retireValid),
    .retireSession  (retireSession),
    .lenFifoFull    (lenFifoFull),
    .strobe         (strobe),
    .status         (linkStatus)
  );

  tcp_rx_datapath #(
    .LEN_W  (LEN_W),
    .KEEP_W (KEEP_W),
    .DEPTH  (LEN_DEPTH),
    .CNT_W  (CNT_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .pushLenValue (rdReqLength),
    .payValid     (payValid),
    .payKeep      (payKeep),
    .payLast      (payLast),
    .payReady     (payReady),
    .lenFifoFull  (lenFifoFull),
    .byteCount    (byteCount),
    .lenError     (lenError)
  );
endmodule

// File: rtl/tcp_rx_checker.sv
module tcp_rx_checker #(
  parameter int DEPTH  = 4,
  parameter int SESS_W = 16,
  parameter int LEN_W  = 16,
  parameter int PORT_W = 16,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              listenValid,
  input logic              listenReady,
  input logic [PORT_W-1:0] listenPort,
  input logic              notifValid,
  input logic              notifReady,
  input logic              notifClosed,
  input logic [SESS_W-1:0] notifSession,
  input logic [LEN_W-1:0]  notifLength,
  input logic              rdReqValid,
  input logic              rdReqReady,
  input logic [SESS_W-1:0] rdReqSession,
  input logic [LEN_W-1:0]  rdReqLength,
  input logic              payValid,
  input logic              payReady,
  input logic              payLast,
  input logic              retireValid,
  input logic [SESS_W-1:0] retireSession,
  input logic [CNT_W-1:0]  byteCount,
  input logic              lenError,
  input logic [1:0]        status
);
  // completed requests whose payload has not yet ended
  int outstanding;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outstanding <= 0;
    end else begin
      outstanding <= outstanding
                   + ((rdReqValid && rdReqReady) ? 1 : 0)
                   - ((payValid && payReady && payLast) ? 1 : 0);
    end
  end

  AST_LISTEN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    listenValid && !listenReady |=> listenValid && $stable(listenPort)); // R1

  AST_FAIL_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    status == 2'd2 |=> status == 2'd2 && !rdReqValid && !notifReady && !listenValid); // R2

  AST_RDREQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    rdReqValid && !rdReqReady |=> rdReqValid && $stable(rdReqSession) && $stable(rdReqLength)); // R3

  AST_CLOSE_RETIRES: assert property (@(posedge clk) disable iff (!rstN)
    notifValid && notifReady && notifClosed |=>
      retireValid && retireSession == $past(notifSession) && !$rose(rdReqValid)); // R4

  AST_ZERO_NO_READ: assert property (@(posedge clk) disable iff (!rstN)
    notifValid && notifReady && !notifClosed && notifLength == '0 |=>
      !$rose(rdReqValid) && !retireValid); // R5

  AST_PAY_AFTER_REQ: assert property (@(posedge clk) disable iff (!rstN)
    payReady |-> outstanding > 0); // R6

  AST_COUNT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !(payValid && payReady) |=> $stable(byteCount)); // R7

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    lenError |=> lenError); // R8

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    outstanding <= DEPTH); // R9

  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    outstanding == DEPTH |-> !notifReady); // R9
endmodule

bind tcp_rx_consumer tcp_rx_checker #(
  .DEPTH  (LEN_DEPTH),
  .SESS_W (SESS_W),
  .LEN_W  (LEN_W),
  .PORT_W (PORT_W),
  .CNT_W  (CNT_W)
) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .listenValid   (listenValid),
  .listenReady   (listenReady),
  .listenPort    (listenPort),
  .notifValid    (notifValid),
  .notifReady    (notifReady),
  .notifClosed   (notifClosed),
  .notifSession  (notifSession),
  .notifLength   (notifLength),
  .rdReqValid    (rdReqValid),
  .rdReqReady    (rdReqReady),
  .rdReqSession  (rdReqSession),
  .rdReqLength   (rdReqLength),
  .payValid      (payValid),
  .payReady      (payReady),
  .payLast       (payLast),
  .retireValid   (retireValid),
  .retireSession (retireSession),
  .byteCount     (byteCount),
  .lenError      (lenError),
  .status        (status)
);

// File: tb/tcp_rx_consumer_tb.sv
module tcp_rx_consumer_tb;
  localparam int SESS_W = 16;
  localparam int LEN_W  = 16;
  localparam int PORT_W = 16;
  localparam int DATA_W = 512;
  localparam int KEEP_W = DATA_W / 8;
  localparam int DEPTH  = 4;
  localparam int CNT_W  = 32;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [PORT_W-1:0] cfgPort = 16'h1F90;
  logic              listenValid;
  logic [PORT_W-1:0] listenPort;
  logic              listenReady = 1'b0;
  logic              listenRspValid = 1'b0;
  logic              listenRspOk = 1'b0;
  logic              listenRspReady;
  logic              notifValid = 1'b0;
  logic [SESS_W-1:0] notifSession = '0;
  logic [LEN_W-1:0]  notifLength = '0;
  logic              notifClosed = 1'b0;
  logic              notifReady;
  logic              rdReqValid;
  logic [SESS_W-1:0] rdReqSession;
  logic [LEN_W-1:0]  rdReqLength;
  logic              rdReqReady = 1'b0;
  logic              payValid = 1'b0;
  logic [KEEP_W-1:0] payKeep = '0;
  logic              payLast = 1'b0;
  logic              payReady;
  logic              retireValid;
  logic [SESS_W-1:0] retireSession;
  logic [CNT_W-1:0]  byteCount;
  logic              lenError;
  logic [1:0]        status;

  always #2 clk = ~clk;  // 250 MHz

  tcp_rx_consumer #(
    .SESS_W(SESS_W), .LEN_W(LEN_W), .PORT_W(PORT_W),
    .DATA_W(DATA_W), .LEN_DEPTH(DEPTH), .CNT_W(CNT_W)
  ) u_dut (
    .clk(clk), .rstN(rstN), .cfgPort(cfgPort),
    .listenValid(listenValid), .listenPort(listenPort), .listenReady(listenReady),
    .listenRspValid(listenRspValid), .listenRspOk(listenRspOk), .listenRspReady(listenRspReady),
    .notifValid(notifValid), .notifSession(notifSession), .notifLength(notifLength),
    .notifClosed(notifClosed), .notifReady(notifReady),
    .rdReqValid(rdReqValid), .rdReqSession(rdReqSession), .rdReqLength(rdReqLength),
    .rdReqReady(rdReqReady),
    .payValid(payValid), .payKeep(payKeep), .payLast(payLast), .payReady(payReady),
    .retireValid(retireValid), .retireSession(retireSession),
    .byteCount(byteCount), .lenError(lenError), .status(status)
  );

  int nChecks = 0;
  int nFail = 0;
  int cyc = 0;

  // behavioural reference model
  int     mState;   // 0 listen req, 1 wait result, 2 running, 3 refused
  bit     mRdV;
  int     mRdSess, mRdLen;
  bit     mRetV;
  int     mRetSess;
  int     mQ[$];
  int     mRem;
  bit     mInRead;
  longint mBytes;
  bit     mErr;
  bit     notifTaken, payTaken, rdTaken, rspTaken;
  int     rdTakenLen;

  // engine-side stimulus state
  int sQ[$];
  int sRem;
  bit sActive;
  int beatCap = 64;
  bit injectErr = 1'b0;
  bit stall = 1'b0;
  bit prevDutRd = 1'b0;
  int dutRdCount = 0, dutRetCount = 0, expRd = 0, expRet = 0;
  longint expBytes = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic bit pNotifReady();
    return (mState == 2) && !mRdV && (mQ.size() < DEPTH);
  endfunction

  function automatic bit pPayReady();
    return (mState == 2) && (mQ.size() > 0);
  endfunction

  function automatic int pStatus();
    return (mState == 2) ? 1 : (mState == 3) ? 2 : 0;
  endfunction

  function automatic logic [KEEP_W-1:0] maskOf(input int b);
    if (b >= KEEP_W) return '1;
    return (KEEP_W'(1) << b) - KEEP_W'(1);
  endfunction

  task automatic modelReset();
    mState = 0; mRdV = 0; mRdSess = 0; mRdLen = 0; mRetV = 0; mRetSess = 0;
    mQ.delete(); mRem = 0; mInRead = 0; mBytes = 0; mErr = 0;
    notifTaken = 0; payTaken = 0; rdTaken = 0; rspTaken = 0;
  endtask

  task automatic modelUpdate();
    bit lt, rt, nt, qt, pt;
    int rem, b;
    bit endE;
    lt = (mState == 0) && listenReady;
    rt = (mState == 1) && listenRspValid;
    nt = notifValid && pNotifReady();
    qt = mRdV && rdReqReady;
    pt = payValid && pPayReady();
    notifTaken = nt; payTaken = pt; rdTaken = qt; rspTaken = rt; rdTakenLen = mRdLen;
    mRetV = 0;
    if (nt && notifClosed) begin mRetV = 1; mRetSess = int'(notifSession); end
    if (pt) begin
      rem = mInRead ? mRem : mQ[0];
      b = $countones(payKeep);
      endE = (b >= rem);
      if (payLast != endE) mErr = 1;
      mBytes += b;
      if (payLast) begin void'(mQ.pop_front()); mInRead = 0; mRem = 0; end
      else begin mRem = endE ? 0 : rem - b; mInRead = 1; end
    end
    if (qt) begin mQ.push_back(mRdLen); mRdV = 0; end
    if (nt && !notifClosed && notifLength != 0) begin
      mRdV = 1; mRdSess = int'(notifSession); mRdLen = int'(notifLength);
    end
    if (lt) mState = 1;
    else if (rt) mState = listenRspOk ? 2 : 3;
  endtask

  task automatic compareAll();
    chk(listenValid == (mState == 0), "R1 listenValid", listenValid, mState == 0);
    if (listenValid) chk(listenPort == cfgPort, "R1 listenPort", listenPort, cfgPort);
    chk(listenRspReady == (mState == 1), "R2 listenRspReady", listenRspReady, mState == 1);
    chk(status == pStatus(), "R2 status", status, pStatus());
    chk(notifReady == pNotifReady(), "R9 notifReady", notifReady, pNotifReady());
    chk(rdReqValid == mRdV, "R3 rdReqValid", rdReqValid, mRdV);
    if (mRdV) begin
      chk(int'(rdReqSession) == mRdSess, "R3 rdReqSession", rdReqSession, mRdSess);
      chk(int'(rdReqLength) == mRdLen, "R3 rdReqLength", rdReqLength, mRdLen);
    end
    chk(retireValid == mRetV, "R4 retireValid", retireValid, mRetV);
    if (mRetV) chk(int'(retireSession) == mRetSess, "R4 retireSession", retireSession, mRetSess);
    chk(payReady == pPayReady(), "R6 payReady", payReady, pPayReady());
    chk(byteCount == CNT_W'(mBytes), "R7 byteCount", byteCount, mBytes);
    chk(lenError == mErr, "R8 lenError", lenError, mErr);
  endtask

  task automatic stackDrive();
    int b;
    if (!rstN) begin
      sQ.delete(); sActive = 0; payValid = 0; payLast = 0; payKeep = '0;
      return;
    end
    if (rdTaken) sQ.push_back(rdTakenLen);
    if (payTaken) begin
      if (payLast) begin void'(sQ.pop_front()); sActive = 0; end
      else sRem -= $countones(payKeep);
      payValid = 0;
    end
    if (!payValid && !stall && sQ.size() > 0 && (cyc % 5) != 4) begin
      if (!sActive) begin sRem = sQ[0]; sActive = 1; end
      b = (sRem < beatCap) ? sRem : beatCap;
      payKeep = maskOf(b);
      payLast = (b >= sRem) || injectErr;
      injectErr = 0;
      payValid = 1;
    end
    rdReqReady = ((cyc % 3) != 1);
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
    if (cyc > 150000) begin
      chk(1'b0, "R6 watchdog expired", cyc, 150000);
      finishRun();
    end
    if (rstN) begin
      if (prevDutRd) dutRdCount++;
      modelUpdate();
    end else begin
      modelReset();
    end
    compareAll();
    if (retireValid) dutRetCount++;
    stackDrive();
    prevDutRd = rdReqValid && rdReqReady;
  endtask

  task automatic doReset();
    rstN = 0;
    listenReady = 0; listenRspValid = 0; notifValid = 0;
    repeat (3) step();
    rstN = 1;
  endtask

  task automatic openListen(input bit ok);
    listenReady = 0;
    repeat (3) step();
    listenReady = 1;
    step();
    listenReady = 0;
    repeat (2) step();
    listenRspValid = 1; listenRspOk = ok;
    for (int i = 0; i < 50 && !rspTaken; i++) step();
    listenRspValid = 0;
  endtask

  task automatic sendNotif(input int sess, input int len, input bit cl);
    notifValid = 1; notifSession = SESS_W'(sess); notifLength = LEN_W'(len); notifClosed = cl;
    notifTaken = 0;
    for (int i = 0; i < 2000 && !notifTaken; i++) step();
    notifValid = 0;
    if (cl) expRet++;
    else if (len != 0) begin expRd++; expBytes += len; end
  endtask

  task automatic drain();
    for (int i = 0; i < 5000 && (sQ.size() > 0 || mRdV || mQ.size() > 0); i++) step();
    repeat (3) step();
  endtask

  initial begin
    modelReset();
    doReset();
    // R1: listen request held while the engine stalls
    step();
    chk(listenValid == 1'b1, "R1 listen offered after reset", listenValid, 1);
    chk(notifReady == 1'b0, "R1 no notification before listen", notifReady, 0);
    openListen(1'b1);
    chk(status == 2'd1, "R2 running after good result", status, 1);

    // R3/R7: single-request patterns with full and partial beats
    sendNotif(5, 64, 0);
    sendNotif(7, 100, 0);
    sendNotif(9, 0, 0);      // R5 zero length dropped
    sendNotif(3, 0, 1);      // R4 plain close
    sendNotif(11, 1, 0);
    sendNotif(12, 200, 1);   // R4 close wins over length
    beatCap = 40;
    sendNotif(13, 130, 0);
    sendNotif(14, 256, 0);
    beatCap = 64;
    sendNotif(15, 63, 0);
    drain();

    // R9: fill the length queue while payload is stalled
    stall = 1;
    sendNotif(20, 70, 0);
    sendNotif(21, 64, 0);
    sendNotif(22, 10, 0);
    sendNotif(23, 128, 0);
    repeat (4) step();
    notifValid = 1; notifSession = 16'd24; notifLength = 16'd33; notifClosed = 0;
    notifTaken = 0;
    repeat (6) step();
    chk(notifReady == 1'b0, "R9 queue full blocks notification", notifReady, 0);
    chk(!notifTaken, "R9 notification not taken while full", notifTaken, 0);
    stall = 0;
    for (int i = 0; i < 2000 && !notifTaken; i++) step();
    notifValid = 0; expRd++; expBytes += 33;
    drain();

    chk(byteCount == CNT_W'(expBytes), "R7 total bytes", byteCount, expBytes);
    chk(lenError == 1'b0, "R8 no error on well-formed streams", lenError, 0);
    chk(dutRdCount == expRd, "R5 read request count", dutRdCount, expRd);
    chk(dutRetCount == expRet, "R4 retire count", dutRetCount, expRet);

    // R8: early last on a multi-beat read
    injectErr = 1;
    sendNotif(30, 150, 0);
    drain();
    chk(lenError == 1'b1, "R8 early last flagged", lenError, 1);
    sendNotif(31, 64, 0);
    drain();
    chk(lenError == 1'b1, "R8 error stays set", lenError, 1);

    // R2: refused listen stops everything
    doReset();
    step();
    chk(lenError == 1'b0, "R8 error cleared by reset", lenError, 0);
    openListen(1'b0);
    chk(status == 2'd2, "R2 refused status", status, 2);
    notifValid = 1; notifSession = 16'd40; notifLength = 16'd64; notifClosed = 0;
    repeat (10) step();
    chk(notifReady == 1'b0, "R2 no notification after refusal", notifReady, 0);
    chk(rdReqValid == 1'b0, "R2 no read after refusal", rdReqValid, 0);
    notifValid = 0;
    repeat (3) step();
    finishRun();
  end
endmodule